// File: doc/BRIEF.md
# DMA Transfer-End Strobe Sequencer

This block sequences one DMA channel through a programmed number of transfer pairs. Each pair is a read then a write. The bus is seen only through three handshake pulses: a read cycle starts, a write cycle starts, and a write cycle completes. While the channel runs, the block drives an active-low end strobe, a one-clock completion interrupt and a busy flag.

A 2-bit timing field, held in a small configuration register, sets where the end strobe is active:
- never;
- from the last read cycle;
- from the last write cycle;
- or as a single-clock pulse that coincides with the completion interrupt.

The configuration register accepts a write only while the channel is idle and transfers are disabled. A write at any other time is dropped.

Top module: `xfer_end_seq`

## Requirements
- R1: After a clock edge with `rst` high, `end_n` is 1, `busy` is 0, `done_irq` is 0, and the timing field is 00.
- R2: With timing field 00, `end_n` stays 1 for the whole transfer and after it.
- R3: With timing field 01, `end_n` goes to 0 in the cycle after the accepted `rd_start` of the final pair. It stays 0 until the final `wr_done` is taken, and is 1 in the cycle `done_irq` is high.
- R4: With timing field 10, `end_n` goes to 0 in the cycle after the accepted `wr_start` of the final pair. It stays 0 until the final `wr_done` is taken, and is 1 in the cycle `done_irq` is high.
- R5: With timing field 11, `end_n` is 0 for exactly one cycle, the same cycle in which `done_irq` is 1.
- R6: `done_irq` is 1 for exactly one cycle, the cycle after the `wr_done` that finishes the final pair.
- R7: `busy` rises in the cycle after an accepted start. A start is accepted when `start` and `enable` are both 1, the channel is idle, and `xfer_cnt` is nonzero. `busy` is 0 in the `done_irq` cycle. A start while busy is ignored.
- R8: A start with `xfer_cnt` equal to 0 leaves `busy`, `done_irq` and `end_n` at their idle values.
- R9: A `cfg_we` write is taken only when the channel is idle and `enable` is 0. Otherwise the timing field keeps its value.
- R10: Within a pair the block takes `rd_start`, then `wr_start`, then `wr_done`. A handshake pulse that arrives out of that order is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing field |
| cfg_mode | input | 2 | Timing field value: 00 off, 01 last read, 10 last write, 11 pulse |
| enable | input | 1 | Transfers enabled |
| start | input | 1 | Start request pulse |
| xfer_cnt | input | CNT_W | Number of read/write pairs, sampled at start |
| rd_start | input | 1 | Pulse: a bus read cycle starts |
| wr_start | input | 1 | Pulse: a bus write cycle starts |
| wr_done | input | 1 | Pulse: the current bus write cycle completes |
| end_n | output | 1 | Active-low transfer-end strobe |
| done_irq | output | 1 | One-clock completion interrupt |
| busy | output | 1 | Channel is running |

## Verification
The assertions assume that every handshake pulse is one cycle wide and lasts one clock. They also assume that the read and write handshakes and the completion handshake are presented only while the channel is busy.

The stimulus keeps to these assumptions. It drives each pair as three separate one-cycle pulses, with a sweep of idle gaps between them, and it returns each pulse low before the next edge. The only deliberate exceptions are out-of-order pulses that the design must discard. The bench sends these early in a transfer, and no assertion claims a strobe change for them.

// File: rtl/xfer_end_seq.sv
module xfer_end_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic             enable,
  input  logic             start,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             rd_start,
  input  logic             wr_start,
  input  logic             wr_done,
  output logic             end_n,
  output logic             done_irq,
  output logic             busy
);

  localparam logic [1:0] M_OFF   = 2'b00;
  localparam logic [1:0] M_RD    = 2'b01;
  localparam logic [1:0] M_WR    = 2'b10;
  localparam logic [1:0] M_PULSE = 2'b11;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_WDONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] rem;
  logic [1:0]       mode_q;
  logic             end_q;
  logic             irq_q;

  wire idle   = (st == S_IDLE);
  wire last   = (rem == ONE);
  wire go     = start & enable & idle & (xfer_cnt != '0);
  wire cfg_ok = cfg_we & ~enable & idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      rem    <= '0;
      mode_q <= M_OFF;
      end_q  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_ok) mode_q <= cfg_mode;
      case (st)
        S_IDLE: begin
          end_q <= 1'b1;
          if (go) begin
            rem <= xfer_cnt;
            st  <= S_RD;
          end
        end
        S_RD: if (rd_start) begin
          st <= S_WR;
          if (last && mode_q == M_RD) end_q <= 1'b0;
        end
        S_WR: if (wr_start) begin
          st <= S_WDONE;
          if (last && mode_q == M_WR) end_q <= 1'b0;
        end
        S_WDONE: if (wr_done) begin
          rem <= rem - ONE;
          if (last) begin
            st    <= S_IDLE;
            irq_q <= 1'b1;
            end_q <= (mode_q != M_PULSE);
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign end_n    = end_q;
  assign done_irq = irq_q;
  assign busy     = ~idle;

endmodule

module xfer_end_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             start,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic             rd_start,
  input logic             wr_start,
  input logic             wr_done,
  input logic             end_n,
  input logic             done_irq,
  input logic             busy,
  input logic [1:0]       mode_q
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (end_n && !busy && !done_irq && mode_q == 2'b00));

  p_off_high_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00) |-> end_n);

  p_rd_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b01 && $fell(end_n)) |-> $past(rd_start));

  p_wr_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b10 && $fell(end_n)) |-> $past(wr_start));

  p_pulse_irq_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11 && !end_n) |-> done_irq);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($past(wr_done) && $past(busy) && !busy));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_done) |=> busy);

  p_zero_cnt_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && xfer_cnt == '0) |=> !busy);

  p_cfg_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (busy || enable) |=> $stable(mode_q));

  p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done_irq) |-> end_n);

endmodule

bind xfer_end_seq xfer_end_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .start(start), .xfer_cnt(xfer_cnt),
  .rd_start(rd_start), .wr_start(wr_start), .wr_done(wr_done),
  .end_n(end_n), .done_irq(done_irq), .busy(busy), .mode_q(mode_q)
);

// File: tb/xfer_end_seq_bench.sv
module xfer_end_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic enable = 1'b0, start = 1'b0;
  logic [CNT_W-1:0] xfer_cnt = '0;
  logic rd_start = 1'b0, wr_start = 1'b0, wr_done = 1'b0;
  logic end_n, done_irq, busy;

  int checks = 0;
  int fails = 0;
  logic exp_end = 1'b1, exp_irq = 1'b0, exp_busy = 1'b0;
  string end_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_end_seq #(.CNT_W(CNT_W)) u_xfer_end_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .enable(enable), .start(start), .xfer_cnt(xfer_cnt),
    .rd_start(rd_start), .wr_start(wr_start), .wr_done(wr_done),
    .end_n(end_n), .done_irq(done_irq), .busy(busy)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    chk(end_tag, end_n, exp_end);
    chk("R6 done_irq", done_irq, exp_irq);
    chk("R7 busy", busy, exp_busy);
  endtask

  function automatic string tag_for(input logic [1:0] m);
    case (m)
      2'b00: return "R2 end_n";
      2'b01: return "R3 end_n";
      2'b10: return "R4 end_n";
      default: return "R5 end_n";
    endcase
  endfunction

  task automatic write_cfg(input logic [1:0] m);
    enable = 1'b0; cfg_we = 1'b1; cfg_mode = m;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic idle_gap(input int g);
    for (int k = 0; k < g; k++) step();
  endtask

  task automatic run_xfer(input logic [1:0] m, input int n, input int gap, input bit inject);
    end_tag = tag_for(m);
    enable = 1'b1; start = 1'b1; xfer_cnt = CNT_W'(n);
    exp_busy = 1'b1;
    step();
    start = 1'b0;
    if (inject) begin
      // R10: write handshakes before the read are ignored
      wr_done = 1'b1; step(); wr_done = 1'b0;
      wr_start = 1'b1; step(); wr_start = 1'b0;
      // R7: start while busy ignored; R9: config write while busy ignored
      start = 1'b1; xfer_cnt = CNT_W'(1); cfg_we = 1'b1; cfg_mode = ~m;
      step();
      start = 1'b0; cfg_we = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      bit lst = (i == n - 1);
      idle_gap(gap);
      rd_start = 1'b1;
      if (lst && m == 2'b01) exp_end = 1'b0;
      step();
      rd_start = 1'b0;
      idle_gap(gap);
      wr_start = 1'b1;
      if (lst && m == 2'b10) exp_end = 1'b0;
      step();
      wr_start = 1'b0;
      idle_gap(gap);
      wr_done = 1'b1;
      if (lst) begin
        exp_irq = 1'b1; exp_busy = 1'b0;
        exp_end = (m == 2'b11) ? 1'b0 : 1'b1;
      end
      step();
      wr_done = 1'b0;
    end
    exp_irq = 1'b0; exp_end = 1'b1;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    end_tag = "R1 end_n";
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    step();

    // R1/R2: mode 00 after reset with no config write
    run_xfer(2'b00, 2, 0, 1'b0);

    // R2-R6: sweep modes, counts, gaps
    for (int m = 0; m < 4; m++)
      for (int n = 1; n <= 4; n++)
        for (int g = 0; g <= 1; g++) begin
          write_cfg(2'(m));
          run_xfer(2'(m), n, g, 1'b0);
        end

    // R7/R9/R10: ignored events inside a busy transfer
    write_cfg(2'b01);
    run_xfer(2'b01, 2, 1, 1'b1);
    // R9: config write with enable high while idle is ignored, mode 01 kept
    enable = 1'b1; cfg_we = 1'b1; cfg_mode = 2'b11;
    step();
    cfg_we = 1'b0;
    run_xfer(2'b01, 1, 0, 1'b0);

    // R8: zero count start
    end_tag = "R8 end_n";
    enable = 1'b1; start = 1'b1; xfer_cnt = '0;
    step();
    start = 1'b0;
    idle_gap(3);
    chk("R8 busy", busy, 1'b0);

    // R1: reset mid-transfer returns mode to 00
    write_cfg(2'b11);
    enable = 1'b1; start = 1'b1; xfer_cnt = CNT_W'(3); exp_busy = 1'b1;
    end_tag = "R5 end_n";
    step();
    start = 1'b0;
    rd_start = 1'b1; step(); rd_start = 1'b0;
    rst = 1'b1; exp_busy = 1'b0; end_tag = "R1 end_n";
    step();
    rst = 1'b0;
    step();
    run_xfer(2'b00, 1, 0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule